// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central control of a small out-of-order machine with four functional units: one integer unit (tag 1), two multipliers (tags 2 and 3) and one adder (tag 4). Tag 0 means "no producer". Decoded instructions arrive one at a time, in program order. Each carries a 3-bit opcode, a destination register and two source registers, out of eight registers. The upper two opcode bits select the unit class: 00 integer, 01 multiply, 10 add, 11 reserved. The low bit is a variant that is stored with the instruction and shown to the datapath.

Each instruction goes through four steps in order:
- **Issue:** the controller allocates a unit.
- **Operand read:** the controller grants the register-file read.
- **Execute:** the unit runs the instruction and raises a done pulse when it finishes.
- **Write-back:** the controller grants the result write.

Every hazard is resolved here, in one place:
- **Output (WAW) conflict:** blocks issue.
- **True (RAW) dependence:** holds the operand read until the producer has written back. There is no forwarding.
- **Anti (WAR) dependence:** holds a finished result until every earlier reader of the old register value has read its operands.

The controller keeps a status record for each unit and a table that maps each register to the unit that will write it next. The datapath executes each operation after its read grant and reports completion through `ex_done`.

Top module: `sb_ctrl`

## Requirements
- R1: After reset, all units are idle and no read grant or write-back grant is raised. `in_ready` is high for a valid class whose destination has no pending writer.
- R2: The class selects the unit: integer goes to tag 1, add to tag 4, and multiply to the lowest-numbered free unit of tags 2 and 3. The reserved class 11 never issues and has no effect on the units. `in_unit` reports the chosen tag.
- R3: When no unit of the requested class is free, `in_ready` stays low. The instruction issues in the cycle after a unit of that class writes back.
- R4: `in_ready` stays low while any in-flight instruction targets the same destination register. Issue becomes possible in the cycle after that writer's write-back cycle.
- R5: A unit's read grant (`rd_go`) is raised no earlier than the cycle after issue. It is raised only when neither source has a pending producer, and only once per instruction.
- R6: An operand produced by another unit is read no earlier than the cycle after that producer's write-back.
- R7: A `ex_done` pulse in the execute step moves the unit to write-back. With no WAR conflict, `wb_go` is raised in the next cycle.
- R8: `wb_go` is held while another unit has not yet read an operand that names the same register as the finishing unit's destination and that was already available to it.
- R9: A write-back frees the unit and clears that register's pending writer, both effective from the next cycle.
- R10: An instruction that issues in the same cycle as the write-back of its source's producer treats that source as available. It reads in the next cycle.
- R11: Issue is in order, at most one instruction per cycle. A stalled instruction blocks all later ones.
- R12: `unit_op` shows the stored opcode of each busy unit, 3 bits per unit with tag 1 in the lowest field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_op | input | 3 | Opcode: [2:1] class, [0] variant |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| in_ready | output | 1 | Issue is granted this cycle if `in_valid` is high |
| in_unit | output | 3 | Tag of the unit the offered instruction would take |
| rd_go | output | 4 | Per unit (bit 0 = tag 1): read operands from the register file now |
| ex_done | input | 4 | Per unit: the result is ready |
| wb_go | output | 4 | Per unit: write the result to the register file now |
| unit_busy | output | 4 | Per unit: the unit holds an instruction |
| unit_op | output | 12 | Stored opcode of each unit |

## Verification
The bench builds the block with its default four units (one integer unit, two multipliers, one adder) and eight registers. It runs each unit at a fixed latency of 1, 4 and 2 cycles respectively. The four-cycle multiply leaves room for a dependent add to be queued behind it while a one-cycle integer operation finishes early. This makes the WAR hold and the RAW wait observable as exact cycle offsets. Having two multipliers makes both the lowest-free-unit choice and the structural stall on a third multiply reachable. A delayed issue lines up a source's producer write-back with the consumer's issue cycle, which exercises the same-cycle case.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NUM_FU   = 4;
  localparam int NUM_REGS = 8;
  localparam int OP_W     = 3;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int TAG_W    = $clog2(NUM_FU + 1);

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [REG_W-1:0] reg_t;
  typedef logic [OP_W-1:0]  op_t;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_RSV = 2'd3
  } fu_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } fu_stage_e;

  // Status record held for each functional unit.
  typedef struct packed {
    logic      busy;
    op_t       op;
    reg_t      fi;
    reg_t      fj;
    reg_t      fk;
    tag_t      qj;
    tag_t      qk;
    logic      rj;
    logic      rk;
    fu_stage_e stage;
  } fu_rec_t;

  // Class requested by an opcode (upper two bits).
  function automatic fu_class_e op_class(op_t op);
    return fu_class_e'(op[OP_W-1 -: 2]);
  endfunction

  // Class served by a unit tag: first is integer, last is adder, rest multiply.
  function automatic fu_class_e unit_class(int tag);
    if (tag == 1)
      return CLS_INT;
    else if (tag == NUM_FU)
      return CLS_ADD;
    else
      return CLS_MUL;
  endfunction

  // A producer tag that writes back this cycle counts as already resolved.
  function automatic tag_t tag_after_wb(tag_t t, logic [NUM_FU-1:0] wb);
    for (int u = 0; u < NUM_FU; u++) begin
      if (wb[u] && t == tag_t'(u + 1)) return '0;
    end
    return t;
  endfunction

  // Reader still needs the old value of register wdst.
  function automatic logic war_conflict(reg_t wdst, reg_t fj, reg_t fk,
                                        logic rj, logic rk, fu_stage_e st);
    return (st == ST_READ) && ((rj && fj == wdst) || (rk && fk == wdst));
  endfunction

endpackage

// File: rtl/sb_unit_sel.sv
module sb_unit_sel
  import sb_pkg::*;
(
  input  logic [NUM_FU-1:0] busy,
  input  fu_class_e         want,
  output logic              found,
  output tag_t              tag
);

  // Descending scan so that the lowest free matching unit wins.
  always_comb begin
    found = 1'b0;
    tag   = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (!busy[i] && unit_class(i + 1) == want) begin
        found = 1'b1;
        tag   = tag_t'(i + 1);
      end
    end
  end

endmodule

// File: rtl/sb_result_table.sv
module sb_result_table
  import sb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  reg_t                    set_reg,
  input  tag_t                    set_tag,
  input  logic [NUM_FU-1:0]       clr_en,
  input  logic [NUM_FU*REG_W-1:0] clr_reg,
  input  reg_t                    rd_a,
  input  reg_t                    rd_b,
  input  reg_t                    rd_d,
  output tag_t                    tag_a,
  output tag_t                    tag_b,
  output tag_t                    tag_d
);

  tag_t tab [NUM_REGS];

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tab[r] <= '0;
        end else begin
          for (int u = 0; u < NUM_FU; u++) begin
            if (clr_en[u] && clr_reg[u*REG_W +: REG_W] == reg_t'(r)
                && tab[r] == tag_t'(u + 1))
              tab[r] <= '0;
          end
          if (set_en && set_reg == reg_t'(r))
            tab[r] <= set_tag;
        end
      end
    end
  endgenerate

  assign tag_a = tab[rd_a];
  assign tag_b = tab[rd_b];
  assign tag_d = tab[rd_d];

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  op_t               a_op,
  input  reg_t              a_dst,
  input  reg_t              a_sa,
  input  reg_t              a_sb,
  input  tag_t              a_qj,
  input  tag_t              a_qk,
  input  logic [NUM_FU-1:0] wb_all,
  input  logic              ex_done,
  input  logic              war_hold,
  output logic              busy,
  output op_t               op,
  output reg_t              fi,
  output reg_t              fj,
  output reg_t              fk,
  output logic              rj,
  output logic              rk,
  output fu_stage_e         stage,
  output logic              rd_go,
  output logic              wb_go
);

  fu_rec_t rec;

  assign rd_go = (rec.stage == ST_READ) && rec.rj && rec.rk;
  assign wb_go = (rec.stage == ST_WB) && !war_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (alloc) begin
      rec.busy  <= 1'b1;
      rec.op    <= a_op;
      rec.fi    <= a_dst;
      rec.fj    <= a_sa;
      rec.fk    <= a_sb;
      rec.qj    <= a_qj;
      rec.qk    <= a_qk;
      rec.rj    <= (a_qj == '0);
      rec.rk    <= (a_qk == '0);
      rec.stage <= ST_READ;
    end else begin
      case (rec.stage)
        ST_READ: begin
          if (rd_go) begin
            rec.stage <= ST_EXEC;
            rec.rj    <= 1'b0;
            rec.rk    <= 1'b0;
          end else begin
            for (int u = 0; u < NUM_FU; u++) begin
              if (wb_all[u] && rec.qj == tag_t'(u + 1)) begin
                rec.qj <= '0;
                rec.rj <= 1'b1;
              end
              if (wb_all[u] && rec.qk == tag_t'(u + 1)) begin
                rec.qk <= '0;
                rec.rk <= 1'b1;
              end
            end
          end
        end
        ST_EXEC: begin
          if (ex_done) rec.stage <= ST_WB;
        end
        ST_WB: begin
          if (wb_go) begin
            rec.busy  <= 1'b0;
            rec.stage <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy  = rec.busy;
  assign op    = rec.op;
  assign fi    = rec.fi;
  assign fj    = rec.fj;
  assign fk    = rec.fk;
  assign rj    = rec.rj;
  assign rk    = rec.rk;
  assign stage = rec.stage;

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [OP_W-1:0]        in_op,
  input  logic [REG_W-1:0]       in_dst,
  input  logic [REG_W-1:0]       in_src_a,
  input  logic [REG_W-1:0]       in_src_b,
  output logic                   in_ready,
  output logic [TAG_W-1:0]       in_unit,
  output logic [NUM_FU-1:0]      rd_go,
  input  logic [NUM_FU-1:0]      ex_done,
  output logic [NUM_FU-1:0]      wb_go,
  output logic [NUM_FU-1:0]      unit_busy,
  output logic [NUM_FU*OP_W-1:0] unit_op
);

  fu_class_e want_cls;
  logic      unit_free;
  tag_t      sel_tag;
  tag_t      tag_a, tag_b, tag_d;
  tag_t      qj_new, qk_new;
  logic      struct_stall;
  logic      waw_stall;
  logic      issue_fire;

  logic [NUM_FU-1:0]       alloc;
  logic [NUM_FU-1:0]       war_hold;
  logic [NUM_FU*REG_W-1:0] unit_dst_flat;

  reg_t      ent_fi    [NUM_FU];
  reg_t      ent_fj    [NUM_FU];
  reg_t      ent_fk    [NUM_FU];
  logic      ent_rj    [NUM_FU];
  logic      ent_rk    [NUM_FU];
  fu_stage_e ent_stage [NUM_FU];
  op_t       ent_op    [NUM_FU];

  assign want_cls = op_class(in_op);

  sb_unit_sel u_sel (
    .busy  (unit_busy),
    .want  (want_cls),
    .found (unit_free),
    .tag   (sel_tag)
  );

  sb_result_table u_rtab (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .set_tag (sel_tag),
    .clr_en  (wb_go),
    .clr_reg (unit_dst_flat),
    .rd_a    (in_src_a),
    .rd_b    (in_src_b),
    .rd_d    (in_dst),
    .tag_a   (tag_a),
    .tag_b   (tag_b),
    .tag_d   (tag_d)
  );

  // Stall reasons, named for observation.
  assign struct_stall = !unit_free;
  assign waw_stall    = (tag_d != '0);
  assign in_ready     = !struct_stall && !waw_stall;
  assign in_unit      = sel_tag;
  assign issue_fire   = in_valid && in_ready;

  // Source producers, with a same-cycle write-back treated as done.
  assign qj_new = tag_after_wb(tag_a, wb_go);
  assign qk_new = tag_after_wb(tag_b, wb_go);

  generate
    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
      assign alloc[g] = issue_fire && (sel_tag == tag_t'(g + 1));

      sb_fu_entry u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc[g]),
        .a_op     (in_op),
        .a_dst    (in_dst),
        .a_sa     (in_src_a),
        .a_sb     (in_src_b),
        .a_qj     (qj_new),
        .a_qk     (qk_new),
        .wb_all   (wb_go),
        .ex_done  (ex_done[g]),
        .war_hold (war_hold[g]),
        .busy     (unit_busy[g]),
        .op       (ent_op[g]),
        .fi       (ent_fi[g]),
        .fj       (ent_fj[g]),
        .fk       (ent_fk[g]),
        .rj       (ent_rj[g]),
        .rk       (ent_rk[g]),
        .stage    (ent_stage[g]),
        .rd_go    (rd_go[g]),
        .wb_go    (wb_go[g])
      );

      assign unit_dst_flat[g*REG_W +: REG_W] = ent_fi[g];
      assign unit_op[g*OP_W +: OP_W]         = ent_op[g];
    end
  endgenerate

  // Anti-dependence hold: another unit still has to read the old value.
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_hold[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && war_conflict(ent_fi[u], ent_fj[f], ent_fk[f],
                                   ent_rj[f], ent_rk[f], ent_stage[f]))
          war_hold[u] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
  import sb_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [TAG_W-1:0]        in_unit,
  input logic [NUM_FU-1:0]       rd_go,
  input logic [NUM_FU-1:0]       wb_go,
  input logic [NUM_FU-1:0]       unit_busy,
  input logic [NUM_FU*REG_W-1:0] unit_dst
);

  generate
    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
      p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_busy[u] |-> (!rd_go[u] && !wb_go[u]));

      p_alloc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_unit == tag_t'(u + 1)) |=> unit_busy[u]);

      p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_unit == tag_t'(u + 1)) |-> !unit_busy[u]);

      p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go[u] |=> !rd_go[u]);

      p_read_not_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go[u] && wb_go[u]));

      p_wb_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_go[u] |=> !unit_busy[u]);

      for (genvar v = 0; v < NUM_FU; v++) begin : g_pair
        if (v > u) begin : g_chk
          p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(unit_busy[u] && unit_busy[v] &&
              unit_dst[u*REG_W +: REG_W] == unit_dst[v*REG_W +: REG_W]));
        end
      end
    end
  endgenerate

endmodule

bind sb_ctrl sb_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_unit   (in_unit),
  .rd_go     (rd_go),
  .wb_go     (wb_go),
  .unit_busy (unit_busy),
  .unit_dst  (unit_dst_flat)
);

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
  import sb_pkg::*;

  localparam op_t OP_INT = 3'b000;
  localparam op_t OP_MUL = 3'b010;
  localparam op_t OP_ADD = 3'b100;
  localparam op_t OP_SUB = 3'b101;
  localparam op_t OP_RSV = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  op_t  in_op = '0;
  reg_t in_dst = '0;
  reg_t in_src_a = '0;
  reg_t in_src_b = '0;
  logic in_ready;
  tag_t in_unit;
  logic [NUM_FU-1:0] ex_done = '0;
  logic [NUM_FU-1:0] rd_go, wb_go, unit_busy;
  logic [NUM_FU*OP_W-1:0] unit_op;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int rd_cyc [NUM_FU];
  int wb_cyc [NUM_FU];
  int cnt    [NUM_FU];

  sb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_ready(in_ready), .in_unit(in_unit), .rd_go(rd_go),
    .ex_done(ex_done), .wb_go(wb_go), .unit_busy(unit_busy),
    .unit_op(unit_op)
  );

  initial forever #5 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // Latency of the fixed-latency datapath model per tag.
  function automatic int lat_of(int tag);
    if (tag == 1) return 1;
    if (tag == NUM_FU) return 2;
    return 4;
  endfunction

  // Datapath model and event recorder.
  initial begin
    for (int u = 0; u < NUM_FU; u++) begin
      cnt[u] = 0; rd_cyc[u] = -1; wb_cyc[u] = -1;
    end
    forever begin
      @(negedge clk);
      for (int u = 0; u < NUM_FU; u++) begin
        ex_done[u] = 1'b0;
        if (!rst_n) cnt[u] = 0;
        else if (rd_go[u]) begin
          cnt[u] = lat_of(u + 1);
          rd_cyc[u] = cyc;
        end else if (cnt[u] > 0) begin
          cnt[u]--;
          if (cnt[u] == 0) ex_done[u] = 1'b1;
        end
        if (rst_n && wb_go[u]) wb_cyc[u] = cyc;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_marks();
    for (int u = 0; u < NUM_FU; u++) begin
      rd_cyc[u] = -1; wb_cyc[u] = -1;
    end
  endtask

  task automatic issue(input op_t op, input reg_t d, input reg_t a, input reg_t b,
                       output int ic, output int unit);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src_a = a; in_src_b = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    ic = cyc;
    unit = int'(in_unit);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (unit_busy != '0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "busy after reset", int'(unit_busy), 0);
    chk("R1", "rd_go after reset", int'(rd_go), 0);
    chk("R1", "wb_go after reset", int'(wb_go), 0);
    in_op = OP_ADD; in_dst = 3'd1;
    #1;
    chk("R1", "ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_single();
    int i, u;
    clear_marks();
    issue(OP_SUB, 3'd1, 3'd2, 3'd3, i, u);
    chk("R2", "add class unit", u, 4);
    chk("R12", "stored op", int'(unit_op[3*OP_W +: OP_W]), int'(OP_SUB));
    chk("R2", "unit busy after issue", int'(unit_busy[3]), 1);
    drain();
    chk("R5", "read cycle", rd_cyc[3] - i, 1);
    chk("R7", "write-back cycle", wb_cyc[3] - i, 4);
    chk("R9", "unit free", int'(unit_busy), 0);
    clear_marks();
    issue(OP_INT, 3'd5, 3'd6, 3'd7, i, u);
    chk("R2", "int class unit", u, 1);
    drain();
    chk("R7", "int write-back cycle", wb_cyc[0] - i, 3);
  endtask

  task automatic t_raw();
    int i, u, j, v;
    clear_marks();
    issue(OP_MUL, 3'd1, 3'd2, 3'd3, i, u);
    issue(OP_ADD, 3'd4, 3'd1, 3'd5, j, v);
    chk("R11", "back-to-back issue", j - i, 1);
    chk("R2", "mul unit", u, 2);
    drain();
    chk("R7", "mul write-back", wb_cyc[1] - i, 6);
    chk("R6", "dependent read after producer write", rd_cyc[3] - wb_cyc[1], 1);
    chk("R6", "dependent write-back", wb_cyc[3] - i, 10);
  endtask

  task automatic t_waw();
    int i, u, j, v, k, w;
    clear_marks();
    issue(OP_ADD, 3'd1, 3'd2, 3'd3, i, u);
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_INT; in_dst = 3'd1; in_src_a = 3'd4; in_src_b = 3'd5;
    #1;
    chk("R4", "ready during output conflict", int'(in_ready), 0);
    in_valid = 1'b0;
    issue(OP_INT, 3'd1, 3'd4, 3'd5, j, v);
    issue(OP_MUL, 3'd6, 3'd7, 3'd7, k, w);
    chk("R4", "issue after writer", j - wb_cyc[3], 1);
    chk("R9", "issue gap for same destination", j - i, 5);
    chk("R11", "later instruction held behind stall", k - i, 6);
    drain();
  endtask

  task automatic t_struct();
    int i, u, j, v, k, w;
    clear_marks();
    issue(OP_MUL, 3'd1, 3'd2, 3'd3, i, u);
    issue(OP_MUL, 3'd2, 3'd3, 3'd4, j, v);
    issue(OP_MUL, 3'd3, 3'd5, 3'd6, k, w);
    chk("R2", "first mul unit", u, 2);
    chk("R2", "second mul unit", v, 3);
    chk("R3", "third mul reuses freed unit", w, 2);
    chk("R3", "third mul issue cycle", k - i, 7);
    drain();
  endtask

  task automatic t_war();
    int i, u, j, v, k, w;
    clear_marks();
    issue(OP_MUL, 3'd4, 3'd5, 3'd6, i, u);
    issue(OP_ADD, 3'd7, 3'd4, 3'd1, j, v);
    issue(OP_INT, 3'd1, 3'd2, 3'd3, k, w);
    drain();
    chk("R5", "int read", rd_cyc[0] - i, 3);
    chk("R6", "add read", rd_cyc[3] - i, 7);
    chk("R8", "int write-back held for reader", wb_cyc[0] - i, 8);
    chk("R8", "write-back after reader", wb_cyc[0] - rd_cyc[3], 1);
  endtask

  task automatic t_same_cycle();
    int i, u, j, v;
    clear_marks();
    issue(OP_INT, 3'd2, 3'd0, 3'd0, i, u);
    repeat (2) @(negedge clk);
    issue(OP_ADD, 3'd3, 3'd2, 3'd2, j, v);
    drain();
    chk("R10", "issue lines up with producer write", j - wb_cyc[0], 0);
    chk("R10", "read next cycle", rd_cyc[3] - j, 1);
    chk("R10", "consumer write-back", wb_cyc[3] - j, 4);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_RSV; in_dst = 3'd0;
    for (int n = 0; n < 3; n++) begin
      #1;
      chk("R2", "reserved class ready", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    chk("R2", "reserved class leaves units idle", int'(unit_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_raw();
    t_waw();
    t_struct();
    t_war();
    t_same_cycle();
    t_reserved();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule